// File: doc/BRIEF.md
# Multi-Channel Prescaled Pulse-Width Modulator

This block produces several independent pulse-width-modulated outputs from one input clock. Each channel owns a 16-bit period counter, a prescaler picked from an eight-entry table of divide ratios, a start count and a stop count that bound the active phase, and a two-bit drive code for each phase. A code can drive the pin high, drive it low or release it. The drive codes let the same channel produce either polarity, or an open-drain style waveform.

Software programs the block through a plain word-wide register bus that has an address, write data, a write strobe and combinational read data. The one shared register holds the channel enables. Software can write it whole, or it can set, clear or toggle chosen bits through three alias addresses, so one channel can be changed without a read-modify-write. Each channel has a pair of registers at a fixed stride. Values written to these registers are held in a shadow copy. A running channel picks up the shadow copy only when its period wraps, so a waveform is never cut short. A synchronous soft-reset input returns the whole block to its reset state.

Top module: `pwm_bank`

## Requirements
- R1: After `rst_n` is low at a clock edge, or after `soft_rst` is high at a clock edge, every register reads 0 and every `pwm_oe` bit is 0.
- R2: The enable register sits at offset 0x00, and bit n enables channel n. Writing 0x00 replaces the whole register. Reading 0x00 returns the enables in bits NUM_CH-1:0, with zeros above them.
- R3: A write to 0x04 sets the written one-bits of the enable register. A write to 0x08 clears them. A write to 0x0C inverts them. Bits written as zero keep their value. Reads of 0x04, 0x08 and 0x0C return the enable register.
- R4: Channel n has a phase register at 0x10 + n*0x20 and a period register at 0x20 + n*0x20. In the phase register, bits 15:0 hold the start count and bits 31:16 hold the stop count. In the period register, bits 15:0 hold the period count P, bits 17:16 hold the active drive code, bits 19:18 hold the idle drive code and bits 22:20 hold the prescaler code. Both registers read back the last written value, with zeros in the unused bits. A write to any other offset changes nothing, and such an offset reads 0.
- R5: An enabled channel's counter reads 0 in the cycle after the enable edge. The counter then advances by one on each prescaled tick and returns to 0 after the tick that finds it at P, so one period is P+1 ticks.
- R6: Prescaler codes 0 to 7 give one tick every 1, 2, 4, 8, 16, 64, 256 and 1024 input clocks. The first tick after enabling comes that many clocks after the enable edge.
- R7: The active drive code applies while start <= count < stop. The idle drive code applies at every other count.
- R8: Drive code 3 drives the pin high with `pwm_oe`=1. Code 2 drives it low with `pwm_oe`=1. Codes 0 and 1 release the pin, giving `pwm_oe`=0 and `pwm_out`=0.
- R9: A disabled channel has `pwm_oe`=0 and `pwm_out`=0, and it holds its counter and prescaler at 0. When it is enabled again, it starts over from count 0.
- R10: A register write to a running channel takes effect at the edge on which its counter wraps to 0. A write to a disabled channel takes effect before the channel is next enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock shared by all channels |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous active-high soft reset of the whole block |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | NUM_CH | Output level of each channel |
| pwm_oe | output | NUM_CH | Output enable of each channel; 0 releases the pin |

## Verification
The assertions assume that both resets are synchronous, and that each write is a single-cycle strobe with address and data valid in that cycle. They also assume that start and stop counts need no particular order, so they put no condition on the phase values. The counter-bound property also relies on a new period being loaded only at a wrap, which holds for any input. The stimulus drives every bus signal on the falling edge, writes one register per call, and configures each channel only while it is disabled or well before its next wrap. This lets the bench know the cycle in which every new value applies.

// File: rtl/pwm_bank_pkg.sv
// Package pwm_bank_pkg
// Shared field layouts and decode helpers for the PWM bank.
// Assumes the period register layout (high to low) is prescaler code,
// idle drive code, active drive code, period count.
package pwm_bank_pkg;

    localparam int CNT_W = 16;
    localparam int PRE_W = 10;

    typedef struct packed {
        logic [2:0]       div_code;
        logic [1:0]       idle_lvl;
        logic [1:0]       act_lvl;
        logic [CNT_W-1:0] period;
    } period_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] stop_at;
        logic [CNT_W-1:0] start_at;
    } phase_cfg_t;

    // Terminal prescaler count (divide ratio minus one) for each code.
    function automatic logic [PRE_W-1:0] prescale_limit(input logic [2:0] code);
        case (code)
            3'd0:    return PRE_W'(0);
            3'd1:    return PRE_W'(1);
            3'd2:    return PRE_W'(3);
            3'd3:    return PRE_W'(7);
            3'd4:    return PRE_W'(15);
            3'd5:    return PRE_W'(63);
            3'd6:    return PRE_W'(255);
            default: return PRE_W'(1023);
        endcase
    endfunction

    // Maps a drive code to {output enable, output level}.
    function automatic logic [1:0] level_drive(input logic [1:0] code);
        case (code)
            2'd3:    return 2'b11;
            2'd2:    return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Module pwm_regs
// Register file of the PWM bank: the enable register with its set, clear
// and toggle aliases, and the shadow phase/period registers of each channel.
// Assumes one write per cycle and a combinational read path.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_we,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH-1:0]        ctrl_en,
    output period_cfg_t [NUM_CH-1:0] per_shadow,
    output phase_cfg_t  [NUM_CH-1:0] ph_shadow
);

    localparam int CTRL_OFS    = 'h00;
    localparam int SET_OFS     = 'h04;
    localparam int CLR_OFS     = 'h08;
    localparam int TOG_OFS     = 'h0C;
    localparam int BANK_BASE   = 'h10;
    localparam int BANK_STRIDE = 'h20;
    localparam int PER_W       = $bits(period_cfg_t);

    logic [NUM_CH-1:0] wdata_ch;
    logic              unused_wbits;

    assign wdata_ch     = bus_wdata[NUM_CH-1:0];
    assign unused_wbits = ^bus_wdata[DATA_W-1:PER_W];

    // Enable register: direct write or set/clear/toggle through the aliases.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_en <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                ADDR_W'(CTRL_OFS): ctrl_en <= wdata_ch;
                ADDR_W'(SET_OFS):  ctrl_en <= ctrl_en | wdata_ch;
                ADDR_W'(CLR_OFS):  ctrl_en <= ctrl_en & ~wdata_ch;
                ADDR_W'(TOG_OFS):  ctrl_en <= ctrl_en ^ wdata_ch;
                default:           ctrl_en <= ctrl_en;
            endcase
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_bank
        localparam logic [ADDR_W-1:0] PH_ADDR  = ADDR_W'(BANK_BASE + n * BANK_STRIDE);
        localparam logic [ADDR_W-1:0] PER_ADDR = ADDR_W'(BANK_BASE + BANK_STRIDE / 2 + n * BANK_STRIDE);

        // Shadow phase register of channel n.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                ph_shadow[n] <= '0;
            end else if (bus_we && bus_addr == PH_ADDR) begin
                ph_shadow[n] <= phase_cfg_t'(bus_wdata[2*CNT_W-1:0]);
            end
        end

        // Shadow period register of channel n.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                per_shadow[n] <= '0;
            end else if (bus_we && bus_addr == PER_ADDR) begin
                per_shadow[n] <= period_cfg_t'(bus_wdata[PER_W-1:0]);
            end
        end
    end

    // Read multiplexer: enables at the four control offsets, banks by stride.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFS) || bus_addr == ADDR_W'(SET_OFS) ||
            bus_addr == ADDR_W'(CLR_OFS)  || bus_addr == ADDR_W'(TOG_OFS)) begin
            bus_rdata = DATA_W'(ctrl_en);
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(BANK_BASE + n * BANK_STRIDE)) begin
                bus_rdata = DATA_W'(ph_shadow[n]);
            end
            if (bus_addr == ADDR_W'(BANK_BASE + BANK_STRIDE / 2 + n * BANK_STRIDE)) begin
                bus_rdata = DATA_W'(per_shadow[n]);
            end
        end
    end

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(SET_OFS) && !soft_rst)
        |=> ((ctrl_en & $past(wdata_ch)) == $past(wdata_ch))); // R3
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(SET_OFS) && !soft_rst)
        |=> ((ctrl_en & $past(ctrl_en)) == $past(ctrl_en))); // R3
    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(CLR_OFS) && !soft_rst)
        |=> ((ctrl_en & $past(wdata_ch)) == '0)); // R3
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_en == '0)); // R1

endmodule

// File: rtl/pwm_prescaler.sv
// Module pwm_prescaler
// Divides the input clock by the ratio selected by a 3-bit code and
// emits a one-cycle tick at the end of each prescaled interval.
// Assumes the code only changes on a tick or while held.
module pwm_prescaler
    import pwm_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic [2:0] div_code,
    output logic       tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    assign limit = prescale_limit(div_code);
    assign tick  = !hold && (pre_cnt == limit);

    // Interval counter: cleared while held, restarts after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    AST_PRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (pre_cnt == '0)); // R9
    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (pre_cnt <= limit)); // R6

endmodule

// File: rtl/pwm_channel.sv
// Module pwm_channel
// One PWM channel: working copies of its configuration, the period counter,
// the phase compare and the drive-code decode.
// Assumes the shadow configuration comes from the register file; it is
// copied in while the channel is disabled and at each period wrap.
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        enable,
    input  period_cfg_t per_shadow,
    input  phase_cfg_t  ph_shadow,
    output logic        pwm_out,
    output logic        pwm_oe
);

    period_cfg_t      per_work;
    phase_cfg_t       ph_work;
    logic [CNT_W-1:0] cnt;
    logic             hold;
    logic             tick;
    logic             wrap;
    logic             active;
    logic [1:0]       drive;

    assign hold = soft_rst || !enable;
    assign wrap = tick && (cnt == per_work.period);

    pwm_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .div_code (per_work.div_code),
        .tick     (tick)
    );

    // Working configuration: follows the shadow while idle, else loads at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            per_work <= '0;
            ph_work  <= '0;
        end else if (!enable || wrap) begin
            per_work <= per_shadow;
            ph_work  <= ph_shadow;
        end
    end

    // Period counter: one step per tick, back to zero after the period count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Phase compare and drive-code decode of the output pin.
    always_comb begin
        active  = (cnt >= ph_work.start_at) && (cnt < ph_work.stop_at);
        drive   = level_drive(active ? per_work.act_lvl : per_work.idle_lvl);
        pwm_oe  = enable && drive[1];
        pwm_out = enable && drive[0];
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (cnt <= per_work.period)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && tick && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1))); // R5
    AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0)); // R9
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !wrap && !soft_rst) |=> ($stable(per_work) && $stable(ph_work))); // R10

endmodule

// File: rtl/pwm_bank.sv
// Module pwm_bank
// Top of the multi-channel PWM bank: a register file plus NUM_CH channels.
// Assumes ADDR_W is wide enough for 0x20 + (NUM_CH-1)*0x20.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_oe
);

    localparam int DATA_W = 32;

    logic [NUM_CH-1:0]        ctrl_en;
    period_cfg_t [NUM_CH-1:0] per_shadow;
    phase_cfg_t  [NUM_CH-1:0] ph_shadow;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .ctrl_en    (ctrl_en),
        .per_shadow (per_shadow),
        .ph_shadow  (ph_shadow)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst   (soft_rst),
            .enable     (ctrl_en[n]),
            .per_shadow (per_shadow[n]),
            .ph_shadow  (ph_shadow[n]),
            .pwm_out    (pwm_out[n]),
            .pwm_oe     (pwm_oe[n])
        );
    end

    AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_oe & ~ctrl_en) == '0) && ((pwm_out & ~pwm_oe) == '0)); // R9

endmodule

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pwm_out;
    logic [N-1:0] pwm_oe;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    ch;
        bit    oe;
        bit    lvl;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_bank #(.NUM_CH(N), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        bus_addr = 8'(a);
        #1;
        chk(tag, int'(bus_rdata), exp);
    endtask

    function automatic logic [31:0] pcfg(int dv, int idle, int act, int p);
        return (32'(dv) << 20) | (32'(idle) << 18) | (32'(act) << 16) | 32'(p);
    endfunction

    // Expected {oe, level} for a drive code (R8 encoding).
    function automatic logic [1:0] drv(int code);
        return (code == 3) ? 2'b11 : (code == 2) ? 2'b10 : 2'b00;
    endfunction

    // Driver: pushes expected pin states for cycles c0+k, counter at (k-k0)/D mod (P+1).
    task automatic push_wave(int ch, int c0, int k0, int k1, int k2, int dv, int p,
                             int s, int e, int act, int idle, string tag);
        for (int k = k1; k <= k2; k++) begin
            exp_t it;
            int   cnt;
            logic [1:0] d;
            cnt = ((k - k0) / dv) % (p + 1);
            d = drv((cnt >= s && cnt < e) ? act : idle);
            it.at = c0 + k; it.ch = ch; it.oe = d[1]; it.lvl = d[0]; it.tag = tag;
            sb.push_back(it);
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: pops expected items due in this cycle and compares the pins.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at <= cyc) begin
                if (sb[i].at < cyc)
                    chk({sb[i].tag, " missed"}, cyc, sb[i].at);
                else
                    chk(sb[i].tag, {pwm_oe[sb[i].ch], pwm_out[sb[i].ch]}, {sb[i].oe, sb[i].lvl});
                sb.delete(i);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 oe after reset", int'(pwm_oe), 0);
        rd_chk("R1 ctrl after reset", 'h00, 0);
        rd_chk("R1 period after reset", 'h20, 0);

        // R2: direct write, bits above NUM_CH read as zero
        wr('h00, 32'hFFFF_FFFF);
        rd_chk("R2 direct all ones", 'h00, 7);
        wr('h00, 32'h5);
        rd_chk("R2 direct 5", 'h00, 5);
        // R3: aliases
        wr('h04, 32'h2);
        rd_chk("R3 set alias", 'h04, 7);
        wr('h08, 32'h5);
        rd_chk("R3 clear alias", 'h08, 2);
        wr('h0C, 32'h3);
        rd_chk("R3 toggle alias", 'h0C, 1);
        wr('h08, 32'h7);
        rd_chk("R3 clear all", 'h00, 0);

        // R4: bank layout, readback and unmapped offsets
        wr('h10, {16'd4, 16'd0});
        wr('h20, pcfg(0, 2, 3, 9));
        rd_chk("R4 phase readback", 'h10, 32'h0004_0000);
        wr('h20, 32'hFFFF_FFFF);
        rd_chk("R4 period unused bits", 'h20, 32'h007F_FFFF);
        wr('h20, pcfg(0, 2, 3, 9));
        wr('h18, 32'hDEAD_BEEF);
        wr('h70, 32'h1234_5678);
        rd_chk("R4 unmapped 0x18 reads 0", 'h18, 0);
        rd_chk("R4 unmapped 0x70 reads 0", 'h70, 0);
        rd_chk("R4 phase after unmapped write", 'h10, 32'h0004_0000);
        rd_chk("R4 period after unmapped write", 'h20, int'(pcfg(0, 2, 3, 9)));

        // R5 R7 R8 R10: ch0 runs P=9 [0,4); new P=4 [1,3) applies at the wrap (k=10)
        wr('h04, 32'h1);
        c = cyc;
        push_wave(0, c, 0, 1, 9, 1, 9, 0, 4, 3, 2, "R5/R7 ch0 first period");
        push_wave(0, c, 10, 10, 29, 1, 4, 1, 3, 3, 2, "R10 ch0 after wrap");
        wr('h10, {16'd3, 16'd1});
        wr('h20, pcfg(0, 2, 3, 4));
        rd_chk("R10 shadow readback", 'h20, int'(pcfg(0, 2, 3, 4)));
        drain();

        // R9: disable releases the pin, re-enable restarts at 0
        wr('h08, 32'h1);
        chk("R9 disabled oe", int'(pwm_oe[0]), 0);
        repeat (3) @(negedge clk);
        chk("R9 disabled out", int'(pwm_out[0]), 0);
        wr('h04, 32'h1);
        c = cyc;
        push_wave(0, c, 0, 1, 12, 1, 4, 1, 3, 3, 2, "R9 restart at zero");
        drain();
        wr('h00, 32'h0);

        // R6 R8: ch1 divide-by-4, ch2 divide-by-64 with a releasing active code
        wr('h30, {16'd3, 16'd1});
        wr('h40, pcfg(2, 2, 3, 3));
        wr('h50, {16'd1, 16'd0});
        wr('h60, pcfg(5, 2, 1, 2));
        wr('h00, 32'h6);
        c = cyc;
        push_wave(1, c, 0, 1, 40, 4, 3, 1, 3, 3, 2, "R6 ch1 code 2");
        push_wave(2, c, 0, 1, 200, 64, 2, 0, 1, 1, 2, "R6/R8 ch2 code 5 release");
        drain();

        // R6: code 7 boundary at 1024 clocks
        wr('h00, 32'h0);
        wr('h60, pcfg(7, 2, 3, 1));
        wr('h50, {16'd2, 16'd1});
        wr('h04, 32'h4);
        c = cyc;
        push_wave(2, c, 0, 1023, 1024, 1024, 1, 1, 2, 3, 2, "R6 code 7 first tick");
        push_wave(2, c, 0, 2047, 2048, 1024, 1, 1, 2, 3, 2, "R6 code 7 wrap");
        drain();

        // R1: soft reset clears everything
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R1 oe after soft reset", int'(pwm_oe), 0);
        rd_chk("R1 ctrl after soft reset", 'h00, 0);
        rd_chk("R1 ch2 period after soft reset", 'h60, 0);
        rd_chk("R1 ch1 phase after soft reset", 'h30, 0);

        finish_run();
    end

endmodule